// File: doc/BRIEF.md
# Grouped-Mask Priority Interrupt Unit

This block collects interrupt requests on a configurable number of levels and picks one at a time for the processor. Each request is held in a sticky register until the processor takes it. A request can only win if it is allowed. A level counts as allowed when the global interrupt enable is set and its group of four neighbouring levels is unmasked. A level built as non-inhibitable is always allowed. Among the allowed pending levels, the lowest-numbered one wins. It is then shown as a registered vector (a base address plus the level number) until it is acknowledged.

The group mask holds one bit per four levels. Software writes it through a 16-bit data port with two strobes, one for the low half and one for the high half. Two other strobes set and clear the global enable. The processor also reports each instruction boundary, and says whether the instruction that just finished was uninterruptible. After such an instruction, no new vector is presented until one more instruction has completed.

Top module: `grp_prio_intc`

## Requirements
- R1: After synchronous reset, the following hold: no vector is valid, no request is pending, every group mask bit is 0 (masked), the global enable is off and the hold-off is clear.
- R2: A high `req_i[i]` at a clock edge makes level i pending. It stays pending until its vector is acknowledged. An acknowledge clears only the acknowledged level. A new request for that same level in the acknowledge cycle keeps it pending.
- R3: When several levels are eligible, the lowest-numbered one is selected (level 0 has top priority).
- R4: A vector is selected at an edge when none is valid and the hold-off is not in force. The selected vector is visible after that edge: `vec_level_o` is the level and `vec_addr_o` = `VEC_BASE` + level. A request latched at edge k can therefore be presented after edge k+1. The vector stays unchanged until `ack_i` is high in a cycle where `vec_valid_o` is high; `vec_valid_o` then drops after that edge.
- R5: Mask bit g enables levels 4g to 4g+3 when it is 1. `mask_lo_we` loads bits 15:0 of the mask from `mask_data`, and `mask_hi_we` loads bits 31:16. The new mask is in effect from the next cycle.
- R6: `permit_i` sets the global enable and `inhibit_i` clears it. If both are high in the same cycle, inhibit wins. While the enable is off, only non-inhibitable levels can be selected.
- R7: An instruction boundary (`instr_done_i`) with `instr_unint_i` high blocks selection in that cycle. Selection stays blocked until the next boundary with `instr_unint_i` low, and that boundary cycle may itself select.
- R8: Levels marked in `NONINH_LEVELS` (by default levels 0 and 1) are eligible whenever pending, whatever the mask and global enable.
- R9: A presented vector is not withdrawn by later mask, enable or hold-off changes. `ack_i` while no vector is valid has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_LEVELS | Request lines, one per level |
| mask_lo_we | input | 1 | Load mask bits 15:0 from mask_data |
| mask_hi_we | input | 1 | Load mask bits 31:16 from mask_data |
| mask_data | input | 16 | Mask half-word to load |
| permit_i | input | 1 | Set global enable |
| inhibit_i | input | 1 | Clear global enable (wins over permit) |
| instr_done_i | input | 1 | Instruction boundary strobe |
| instr_unint_i | input | 1 | Finished instruction was uninterruptible (valid with instr_done_i) |
| ack_i | input | 1 | Acknowledge of the presented vector |
| vec_valid_o | output | 1 | A vector is presented |
| vec_level_o | output | $clog2(NUM_LEVELS) | Level of the presented vector |
| vec_addr_o | output | VEC_W | VEC_BASE plus level |

## Verification
Two kinds of event can land in the same cycle, and both are driven on purpose.

- **Boundary and selection.** An instruction boundary can coincide with a selection decision. The bench keeps a request pending under hold-off, then issues an ordinary boundary. It checks that the vector appears right after that same edge. It also checks that a boundary flagged uninterruptible blocks the edge it falls on.
- **Acknowledge and re-request.** An acknowledge can coincide with a new request on the same level. The bench drives both together and expects the level to be presented again.

A behavioural reference model judges every cycle in addition to these directed checks.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int HALF_W   = 16;
  localparam int GRP_SIZE = 4;
  localparam int MAX_LEVELS = 128;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int NUM_LEVELS = 128,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] req_i,
  input  logic                  clr_en,
  input  logic [LVL_W-1:0]      clr_lvl,
  output logic [NUM_LEVELS-1:0] pend_q
);
  logic [NUM_LEVELS-1:0] clr_vec;

  always_comb begin
    for (int i = 0; i < NUM_LEVELS; i++)
      clr_vec[i] = clr_en && (clr_lvl == LVL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_vec) | req_i;
  end
endmodule

// File: rtl/pic_gate.sv
module pic_gate #(
  parameter int NUM_LEVELS = 128,
  parameter logic [NUM_LEVELS-1:0] NONINH_LEVELS = 'b11,
  localparam int NUM_GROUPS = NUM_LEVELS / pic_pkg::GRP_SIZE
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mask_lo_we,
  input  logic                       mask_hi_we,
  input  logic [pic_pkg::HALF_W-1:0] mask_data,
  input  logic                       permit_i,
  input  logic                       inhibit_i,
  input  logic [NUM_LEVELS-1:0]      pend_q,
  output logic [NUM_LEVELS-1:0]      elig,
  output logic [NUM_GROUPS-1:0]      mask_q,
  output logic                       gen_q
);
  always_ff @(posedge clk) begin
    if (rst)            gen_q <= 1'b0;
    else if (inhibit_i) gen_q <= 1'b0;
    else if (permit_i)  gen_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int HALF = g / pic_pkg::HALF_W;
    localparam int BITI = g % pic_pkg::HALF_W;
    logic load;
    assign load = (HALF == 0) ? mask_lo_we : mask_hi_we;

    always_ff @(posedge clk) begin
      if (rst)       mask_q[g] <= 1'b0;
      else if (load) mask_q[g] <= mask_data[BITI];
    end

    for (genvar k = 0; k < pic_pkg::GRP_SIZE; k++) begin : g_lvl
      localparam int L = g * pic_pkg::GRP_SIZE + k;
      assign elig[L] = pend_q[L] & (NONINH_LEVELS[L] | (gen_q & mask_q[g]));
    end
  end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int NUM_LEVELS = 128,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] elig,
  output logic                  any,
  output logic [LVL_W-1:0]      win
);
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any = 1'b1;
        win = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/grp_prio_intc.sv
module grp_prio_intc #(
  parameter int NUM_LEVELS = 128,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0100,
  parameter logic [NUM_LEVELS-1:0] NONINH_LEVELS = 'b11,
  localparam int LVL_W = $clog2(NUM_LEVELS),
  localparam int NUM_GROUPS = NUM_LEVELS / pic_pkg::GRP_SIZE
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LEVELS-1:0]      req_i,
  input  logic                       mask_lo_we,
  input  logic                       mask_hi_we,
  input  logic [pic_pkg::HALF_W-1:0] mask_data,
  input  logic                       permit_i,
  input  logic                       inhibit_i,
  input  logic                       instr_done_i,
  input  logic                       instr_unint_i,
  input  logic                       ack_i,
  output logic                       vec_valid_o,
  output logic [LVL_W-1:0]           vec_level_o,
  output logic [VEC_W-1:0]           vec_addr_o
);
  logic [NUM_LEVELS-1:0] pend_q, elig;
  logic [NUM_GROUPS-1:0] mask_q;
  logic                  gen_q, hold_q, hold_eff, ack_fire, take, any;
  logic [LVL_W-1:0]      win;

  assign hold_eff = instr_done_i ? instr_unint_i : hold_q;
  assign ack_fire = vec_valid_o & ack_i;
  assign take     = ~vec_valid_o & ~hold_eff & any;

  pic_req_latch #(.NUM_LEVELS(NUM_LEVELS)) u_latch (
    .clk(clk), .rst(rst), .req_i(req_i),
    .clr_en(ack_fire), .clr_lvl(vec_level_o), .pend_q(pend_q)
  );

  pic_gate #(.NUM_LEVELS(NUM_LEVELS), .NONINH_LEVELS(NONINH_LEVELS)) u_gate (
    .clk(clk), .rst(rst), .mask_lo_we(mask_lo_we), .mask_hi_we(mask_hi_we),
    .mask_data(mask_data), .permit_i(permit_i), .inhibit_i(inhibit_i),
    .pend_q(pend_q), .elig(elig), .mask_q(mask_q), .gen_q(gen_q)
  );

  pic_prio_enc #(.NUM_LEVELS(NUM_LEVELS)) u_enc (
    .elig(elig), .any(any), .win(win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_level_o <= '0;
      vec_addr_o  <= '0;
    end else begin
      if (instr_done_i) hold_q <= instr_unint_i;
      if (ack_fire) begin
        vec_valid_o <= 1'b0;
      end else if (take) begin
        vec_valid_o <= 1'b1;
        vec_level_o <= win;
        vec_addr_o  <= VEC_BASE + VEC_W'(win);
      end
    end
  end
endmodule

// File: rtl/grp_prio_intc_chk.sv
module grp_prio_intc_chk #(
  parameter int NUM_LEVELS = 128,
  parameter logic [NUM_LEVELS-1:0] NONINH_LEVELS = 'b11,
  localparam int LVL_W = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  vec_valid_o,
  input logic [LVL_W-1:0]      vec_level_o,
  input logic                  ack_i,
  input logic                  instr_done_i,
  input logic                  instr_unint_i,
  input logic                  hold_q,
  input logic                  gen_q,
  input logic [NUM_LEVELS-1:0] pend_q,
  input logic [NUM_LEVELS-1:0] elig
);
  // R4
  p_vec_held_r4: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o && !ack_i |=> vec_valid_o && $stable(vec_level_o));
  // R2
  p_ack_drops_r2: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o && ack_i |=> !vec_valid_o);
  // R2
  p_grant_pending_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_valid_o) |-> (($past(pend_q) >> vec_level_o) & NUM_LEVELS'(1)) != '0);
  // R3
  p_lowest_wins_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_valid_o) |->
      ($past(elig) & ((NUM_LEVELS'(1) << vec_level_o) - NUM_LEVELS'(1))) == '0);
  // R7
  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    !vec_valid_o && hold_q && !instr_done_i |=> !vec_valid_o);
  // R7
  p_unint_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    !vec_valid_o && instr_done_i && instr_unint_i |=> !vec_valid_o);
  // R6
  p_gated_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_valid_o) && !NONINH_LEVELS[vec_level_o] |-> $past(gen_q));
endmodule

bind grp_prio_intc grp_prio_intc_chk #(
  .NUM_LEVELS(NUM_LEVELS), .NONINH_LEVELS(NONINH_LEVELS)
) u_chk (
  .clk(clk), .rst(rst), .vec_valid_o(vec_valid_o), .vec_level_o(vec_level_o),
  .ack_i(ack_i), .instr_done_i(instr_done_i), .instr_unint_i(instr_unint_i),
  .hold_q(hold_q), .gen_q(gen_q), .pend_q(pend_q), .elig(elig)
);

// File: tb/grp_prio_intc_tb.sv
module grp_prio_intc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 128;
  localparam int LW = $clog2(NL);
  localparam int VW = 16;
  localparam int BASE = 'h0100;

  logic clk = 0, rst = 1;
  logic [NL-1:0] req_i = '0;
  logic mask_lo_we = 0, mask_hi_we = 0;
  logic [15:0] mask_data = '0;
  logic permit_i = 0, inhibit_i = 0, instr_done_i = 0, instr_unint_i = 0, ack_i = 0;
  logic vec_valid_o;
  logic [LW-1:0] vec_level_o;
  logic [VW-1:0] vec_addr_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_prio_intc u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .mask_lo_we(mask_lo_we),
    .mask_hi_we(mask_hi_we), .mask_data(mask_data), .permit_i(permit_i),
    .inhibit_i(inhibit_i), .instr_done_i(instr_done_i),
    .instr_unint_i(instr_unint_i), .ack_i(ack_i), .vec_valid_o(vec_valid_o),
    .vec_level_o(vec_level_o), .vec_addr_o(vec_addr_o)
  );

  // reference model
  bit m_pend[NL];
  bit m_mask[32];
  bit m_gen, m_hold, m_valid;
  int m_lvl;

  function automatic bit noninh(int l);
    return (l == 0) || (l == 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      foreach (m_mask[i]) m_mask[i] = 0;
      m_gen = 0; m_hold = 0; m_valid = 0; m_lvl = 0;
    end else begin
      bit he;
      int clr;
      clr = -1;
      he = instr_done_i ? instr_unint_i : m_hold;
      if (m_valid && ack_i) begin
        m_valid = 0; clr = m_lvl;
      end else if (!m_valid && !he) begin
        for (int i = 0; i < NL; i++)
          if (m_pend[i] && (noninh(i) || (m_gen && m_mask[i/4]))) begin
            m_valid = 1; m_lvl = i; break;
          end
      end
      for (int i = 0; i < NL; i++) m_pend[i] = (m_pend[i] && i != clr) || req_i[i];
      for (int b = 0; b < 16; b++) begin
        if (mask_lo_we) m_mask[b] = mask_data[b];
        if (mask_hi_we) m_mask[b+16] = mask_data[b];
      end
      if (inhibit_i) m_gen = 0; else if (permit_i) m_gen = 1;
      if (instr_done_i) m_hold = instr_unint_i;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(vec_valid_o == m_valid, "MODEL valid (R4)", vec_valid_o, m_valid);
      if (m_valid) begin
        chk(vec_level_o == m_lvl, "MODEL level (R3)", vec_level_o, m_lvl);
        chk(vec_addr_o == BASE + m_lvl, "MODEL addr (R4)", vec_addr_o, BASE + m_lvl);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic req(int l);
    req_i[l] = 1; cyc(1); req_i = '0;
  endtask
  task automatic ack();
    ack_i = 1; cyc(1); ack_i = 0;
  endtask
  task automatic load_lo(logic [15:0] d);
    mask_lo_we = 1; mask_data = d; cyc(1); mask_lo_we = 0;
  endtask
  task automatic load_hi(logic [15:0] d);
    mask_hi_we = 1; mask_data = d; cyc(1); mask_hi_we = 0;
  endtask
  task automatic permit();
    permit_i = 1; cyc(1); permit_i = 0;
  endtask
  task automatic inhibit();
    inhibit_i = 1; cyc(1); inhibit_i = 0;
  endtask
  task automatic boundary(bit unint);
    instr_done_i = 1; instr_unint_i = unint; cyc(1);
    instr_done_i = 0; instr_unint_i = 0;
  endtask
  task automatic expect_vec(int l, string tag);
    chk(vec_valid_o == 1, tag, vec_valid_o, 1);
    chk(vec_level_o == l, tag, vec_level_o, l);
    chk(vec_addr_o == BASE + l, tag, vec_addr_o, BASE + l);
  endtask
  task automatic expect_none(string tag);
    chk(vec_valid_o == 0, tag, vec_valid_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3); rst = 0;
    cyc(1); expect_none("R1 reset no vector");
    req(8); cyc(3); expect_none("R1 masked and inhibited after reset");
    load_lo(16'h0004); cyc(3); expect_none("R6 global inhibit blocks");
    permit(); cyc(2); expect_vec(8, "R5 R6 group 2 enabled");
    inhibit(); load_lo(16'h0000); cyc(2); expect_vec(8, "R9 vector not withdrawn");
    ack(); expect_none("R2 ack drops vector");
    load_lo(16'h0004); permit(); cyc(3); expect_none("R2 acked level cleared");
    // R3 priority among several
    req_i[10] = 1; req_i[9] = 1; req_i[5] = 1; cyc(1); req_i = '0;
    cyc(2); expect_vec(9, "R3 lowest eligible wins");
    ack(); cyc(1); expect_vec(10, "R3 next level after ack");
    ack(); cyc(3); expect_none("R5 group 1 masked keeps level 5 out");
    load_lo(16'h0006); cyc(2); expect_vec(5, "R5 low half load enables group 1");
    ack();
    req(70); cyc(3); expect_none("R5 group 17 masked");
    load_hi(16'h0002); cyc(2); expect_vec(70, "R5 high half load enables group 17");
    ack();
    // R8 non-inhibitable
    inhibit(); load_lo(16'h0000);
    req(1); cyc(2); expect_vec(1, "R8 non-inhibitable bypasses mask and inhibit");
    ack();
    req(4); cyc(3); expect_none("R6 inhibited level 4 held");
    permit_i = 1; inhibit_i = 1; cyc(1); permit_i = 0; inhibit_i = 0;
    load_lo(16'h0002); cyc(3); expect_none("R6 inhibit wins over permit");
    permit(); cyc(2); expect_vec(4, "R6 permit releases level 4");
    ack();
    // R7 hold-off
    load_lo(16'h0004);
    instr_done_i = 1; instr_unint_i = 1; req_i[8] = 1; cyc(1);
    instr_done_i = 0; instr_unint_i = 0; req_i = '0;
    cyc(3); expect_none("R7 hold-off after uninterruptible");
    ack(); cyc(1); expect_none("R9 idle ack ignored");
    boundary(1); cyc(2); expect_none("R7 chained uninterruptible keeps hold");
    boundary(0); expect_vec(8, "R7 selection on releasing boundary");
    // R2 ack and re-request together
    ack_i = 1; req_i[8] = 1; cyc(1); ack_i = 0; req_i = '0;
    expect_none("R2 ack drops vector");
    cyc(1); expect_vec(8, "R2 re-request in ack cycle kept");
    ack(); cyc(3); expect_none("R2 all cleared");
    // R4 latency: request then two edges
    req(9); expect_none("R4 not yet presented"); cyc(1); expect_vec(9, "R4 vector one cycle after latch");
    ack(); cyc(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule